// File: doc/BRIEF.md
# Snoopy Invalidate Coherence Controller

This block keeps the second-level caches of a small shared-bus multiprocessor coherent. Each processor has its own controller, and each controller holds a three-state ownership code for every tracked line: invalid, shared (read-only) or exclusive (read-write). The caches are write-back with write-allocate. A miss fetches the line over the memory bus. Every other controller snoops that fetch, and a peer that holds the line exclusive writes it back and keeps it as shared. To make a line writable, a controller broadcasts an invalidate on a dedicated control bus, which runs beside the memory bus and never takes memory-bus cycles. Peers then drop their copies.

The top module groups the per-processor controllers with one fixed-priority arbiter for each bus. Software-visible data is out of scope: the block tracks ownership and reports bus activity and write-back strobes, but it does not move data. A non-coherent write is passed through without touching any ownership state, so the result of a computation can reach memory without pulling a line into the cache.

Top module: `smp_snoop_coh`

## Requirements
- R1: After reset every line of every processor is invalid, every request port is ready, no done strobe is high, neither bus carries a transaction and no write-back strobe is high.
- R2: A read (op code 0, or the spare code 3, which also reads) of a shared or exclusive line, or a write (op code 1) to an exclusive line, raises done two cycles after the request is accepted, with no bus traffic.
- R3: Every request spends at least one coherence lookup cycle: done is never high in the cycle that follows acceptance, and the port is not ready again until after done.
- R4: A read of an invalid line issues one memory-bus fetch that carries the requester's index and the line address. The line becomes shared and done follows one cycle after the grant.
- R5: When a peer holding the fetched line exclusive sees the fetch, it raises its write-back strobe in the same cycle and keeps the line as shared.
- R6: A write to a shared line issues one control-bus invalidate that carries the requester's index and the line address. Every peer copy becomes invalid, the requester's line becomes exclusive and done follows one cycle after the grant.
- R7: A write to an invalid line first fetches over the memory bus and then invalidates over the control bus. It ends exclusive, with done four cycles after acceptance when neither bus is contended.
- R8: A non-coherent write (op code 2) completes two cycles after acceptance with no bus traffic and no write-back, and it leaves every processor's state for that line unchanged. A missing line is not allocated.
- R9: On each bus at most one requester is granted per cycle, and the lowest processor index wins. Losers keep requesting.
- R10: A controller waiting to invalidate whose own shared copy is invalidated by a peer re-fetches the line over the memory bus before it invalidates again.
- R11: A control-bus request whose line equals the line being fetched on the memory bus in that cycle is held back for that cycle.
- R12: At any time a line that is exclusive in one cache is invalid in all other caches, and no line carries an undefined state code.
- R13: A write-back strobe is raised only in a cycle that carries bus traffic from another processor that hits an exclusive line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Per-processor request strobe, accepted while ready |
| req_op | input | 2*NCPU | Per-processor op: 0 read, 1 write, 2 non-coherent write, 3 read |
| req_addr | input | IDX_W*NCPU | Per-processor line index |
| req_ready | output | NCPU | Controller idle and able to accept |
| req_done | output | NCPU | One-cycle completion strobe |
| mbus_valid | output | 1 | Memory-bus fetch in this cycle |
| mbus_src | output | SRC_W | Index of the fetching processor |
| mbus_addr | output | IDX_W | Line being fetched |
| cbus_valid | output | 1 | Control-bus invalidate in this cycle |
| cbus_src | output | SRC_W | Index of the invalidating processor |
| cbus_addr | output | IDX_W | Line being invalidated |
| wb | output | NCPU | Per-processor write-back strobe |

## Verification
A wrong ownership code is not visible when it is formed. It shows up at the next access to that line from any processor. A stale shared or exclusive copy turns an expected fetch into a silent hit (missing mbus or cbus cycle, done one cycle early). A lost exclusive copy removes a write-back strobe from the next peer fetch. A spurious copy adds an invalidate or changes a latency from two cycles to three. The bench therefore runs chains of accesses to one line across processors. Each chain is built so that every step's traffic and latency depends on the states left by the step before, and a corrupted state is reported within four cycles of the next request. Contended cases check the arbitration order and the re-fetch path cycle by cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD     = 2'd0,
        OP_WR     = 2'd1,
        OP_NCW    = 2'd2,
        OP_RD_ALT = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_MBUS  = 3'd2,
        ST_CBUS  = 3'd3,
        ST_DONE  = 3'd4
    } ctl_fsm_e;

endpackage

// File: rtl/coh_prio_arb.sv
module coh_prio_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                gnt_o[i] = 1'b1;
                idx_o    = IW'(i);
                any_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/coh_node_ctrl.sv
module coh_node_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [1:0]         req_op_i,
    input  logic [IDX_W-1:0]   req_addr_i,
    output logic               req_ready_o,
    output logic               req_done_o,
    output logic               mreq_o,
    output logic               creq_o,
    input  logic               mgnt_i,
    input  logic               cgnt_i,
    input  logic               mb_valid_i,
    input  logic [IDX_W-1:0]   mb_addr_i,
    input  logic               cb_valid_i,
    input  logic [IDX_W-1:0]   cb_addr_i,
    output logic [IDX_W-1:0]   cur_addr_o,
    output logic               wb_o,
    output logic [2*LINES-1:0] st_o
);

    typedef struct packed {
        ctl_fsm_e                fsm;
        req_op_e                 op;
        logic [IDX_W-1:0]        addr;
        logic [LINES-1:0][1:0]   lines;
    } node_t;

    node_t      q, d;
    logic [1:0] own;

    always_comb begin
        d      = q;
        wb_o   = 1'b0;
        mreq_o = 1'b0;
        creq_o = 1'b0;
        own    = q.lines[q.addr];

        // traffic from other processors: a fetch downgrades an owner
        if (mb_valid_i && !mgnt_i && q.lines[mb_addr_i] == LN_EXC) begin
            d.lines[mb_addr_i] = LN_SHR;
            wb_o               = 1'b1;
        end
        // an invalidate removes any copy, writing back an owned one first
        if (cb_valid_i && !cgnt_i && q.lines[cb_addr_i] != LN_INV) begin
            if (q.lines[cb_addr_i] == LN_EXC) begin
                wb_o = 1'b1;
            end
            d.lines[cb_addr_i] = LN_INV;
        end

        unique case (q.fsm)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.fsm  = ST_CHECK;
                    d.op   = req_op_e'(req_op_i);
                    d.addr = req_addr_i;
                end
            end
            ST_CHECK: begin
                unique case (q.op)
                    OP_NCW: d.fsm = ST_DONE;
                    OP_WR: begin
                        if (own == LN_EXC)      d.fsm = ST_DONE;
                        else if (own == LN_SHR) d.fsm = ST_CBUS;
                        else                    d.fsm = ST_MBUS;
                    end
                    default: begin
                        if (own != LN_INV) d.fsm = ST_DONE;
                        else               d.fsm = ST_MBUS;
                    end
                endcase
            end
            ST_MBUS: begin
                mreq_o = 1'b1;
                if (mgnt_i) begin
                    d.lines[q.addr] = LN_SHR;
                    d.fsm = (q.op == OP_WR) ? ST_CBUS : ST_DONE;
                end
            end
            ST_CBUS: begin
                if (own == LN_INV) begin
                    d.fsm = ST_MBUS;
                end else begin
                    creq_o = 1'b1;
                    if (cgnt_i) begin
                        d.lines[q.addr] = LN_EXC;
                        d.fsm           = ST_DONE;
                    end
                end
            end
            default: d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.fsm   <= ST_IDLE;
            q.op    <= OP_RD;
            q.addr  <= '0;
            q.lines <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = (q.fsm == ST_IDLE);
    assign req_done_o  = (q.fsm == ST_DONE);
    assign cur_addr_o  = q.addr;
    assign st_o        = q.lines;

endmodule

// File: rtl/smp_snoop_coh.sv
module smp_snoop_coh
    import coh_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int SRC_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCPU-1:0]       req_valid,
    input  logic [2*NCPU-1:0]     req_op,
    input  logic [IDX_W*NCPU-1:0] req_addr,
    output logic [NCPU-1:0]       req_ready,
    output logic [NCPU-1:0]       req_done,
    output logic                  mbus_valid,
    output logic [SRC_W-1:0]      mbus_src,
    output logic [IDX_W-1:0]      mbus_addr,
    output logic                  cbus_valid,
    output logic [SRC_W-1:0]      cbus_src,
    output logic [IDX_W-1:0]      cbus_addr,
    output logic [NCPU-1:0]       wb
);

    logic [NCPU-1:0]              mreq, creq, creq_ok, mgnt, cgnt;
    logic [NCPU-1:0][IDX_W-1:0]   cur_addr;
    logic [NCPU-1:0][2*LINES-1:0] all_st;

    for (genvar i = 0; i < NCPU; i++) begin : g_node
        coh_node_ctrl #(
            .LINES (LINES),
            .IDX_W (IDX_W)
        ) u_node (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid_i (req_valid[i]),
            .req_op_i    (req_op[2*i +: 2]),
            .req_addr_i  (req_addr[IDX_W*i +: IDX_W]),
            .req_ready_o (req_ready[i]),
            .req_done_o  (req_done[i]),
            .mreq_o      (mreq[i]),
            .creq_o      (creq[i]),
            .mgnt_i      (mgnt[i]),
            .cgnt_i      (cgnt[i]),
            .mb_valid_i  (mbus_valid),
            .mb_addr_i   (mbus_addr),
            .cb_valid_i  (cbus_valid),
            .cb_addr_i   (cbus_addr),
            .cur_addr_o  (cur_addr[i]),
            .wb_o        (wb[i]),
            .st_o        (all_st[i])
        );
        // hold back an invalidate for the line being fetched this cycle
        assign creq_ok[i] = creq[i] && !(mbus_valid && cur_addr[i] == mbus_addr);
    end

    coh_prio_arb #(.N(NCPU), .IW(SRC_W)) u_mbus_arb (
        .req_i (mreq),
        .gnt_o (mgnt),
        .any_o (mbus_valid),
        .idx_o (mbus_src)
    );

    coh_prio_arb #(.N(NCPU), .IW(SRC_W)) u_cbus_arb (
        .req_i (creq_ok),
        .gnt_o (cgnt),
        .any_o (cbus_valid),
        .idx_o (cbus_src)
    );

    assign mbus_addr = cur_addr[mbus_src];
    assign cbus_addr = cur_addr[cbus_src];

endmodule

// File: rtl/smp_snoop_coh_chk.sv
module smp_snoop_coh_chk #(
    parameter int NCPU  = 4,
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NCPU-1:0]              req_valid,
    input logic [NCPU-1:0]              req_ready,
    input logic [NCPU-1:0]              req_done,
    input logic                         mbus_valid,
    input logic [IDX_W-1:0]             mbus_addr,
    input logic                         cbus_valid,
    input logic [IDX_W-1:0]             cbus_addr,
    input logic [NCPU-1:0]              wb,
    input logic [NCPU-1:0][2*LINES-1:0] all_st
);

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [NCPU-1:0] exc, held, bad;
        always_comb begin
            for (int c = 0; c < NCPU; c++) begin
                exc[c]  = (all_st[c][2*l +: 2] == 2'd2);
                held[c] = (all_st[c][2*l +: 2] != 2'd0);
                bad[c]  = (all_st[c][2*l +: 2] == 2'd3);
            end
        end
        // R12: an owner is the only holder
        a_r12_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            (|exc) |-> ($countones(held) == 1));
        // R12: no undefined code
        a_r12_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            !(|bad));
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        a_r3_lookup_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[c] && req_ready[c]) |=> (!req_done[c] && !req_ready[c]));
        a_r3_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
            req_done[c] |=> (req_ready[c] && !req_done[c]));
    end

    a_r11_bus_lines_differ: assert property (@(posedge clk) disable iff (!rst_n)
        (mbus_valid && cbus_valid) |-> (mbus_addr != cbus_addr));

    a_r13_wb_needs_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb) |-> (mbus_valid || cbus_valid));

endmodule

bind smp_snoop_coh smp_snoop_coh_chk #(
    .NCPU  (NCPU),
    .LINES (LINES),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_done   (req_done),
    .mbus_valid (mbus_valid),
    .mbus_addr  (mbus_addr),
    .cbus_valid (cbus_valid),
    .cbus_addr  (cbus_addr),
    .wb         (wb),
    .all_st     (all_st)
);

// File: tb/smp_snoop_coh_test.sv
`timescale 1ns/1ps
module smp_snoop_coh_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_valid = '0;
    logic [7:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_ready, req_done, wb;
    logic        mbus_valid, cbus_valid;
    logic [1:0]  mbus_src, cbus_src;
    logic [3:0]  mbus_addr, cbus_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    smp_snoop_coh uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_ready(req_ready), .req_done(req_done),
        .mbus_valid(mbus_valid), .mbus_src(mbus_src), .mbus_addr(mbus_addr),
        .cbus_valid(cbus_valid), .cbus_src(cbus_src), .cbus_addr(cbus_addr),
        .wb(wb)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // row: cpu[20:19] op[18:17] addr[16:13] lat[12:10] mbv[9] mbs[8:7] cbv[6] cbs[5:4] wb[3:0]
    // bus fields: valid*4+src; lat counts falling edges from the drive edge to done
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 2'd0, 4'd3, 3'd3, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000}, // R1 R4 cold read miss
        {2'd0, 2'd0, 4'd3, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}, // R2 read hit shared
        {2'd0, 2'd1, 4'd3, 3'd3, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0000}, // R6 upgrade
        {2'd0, 2'd1, 4'd3, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}, // R2 write hit exclusive
        {2'd1, 2'd0, 4'd3, 3'd3, 1'b1, 2'd1, 1'b0, 2'd0, 4'b0001}, // R5 owner writes back
        {2'd2, 2'd1, 4'd3, 3'd4, 1'b1, 2'd2, 1'b1, 2'd2, 4'b0000}, // R7 write miss
        {2'd0, 2'd0, 4'd3, 3'd3, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0100}, // R5 downgrade cpu2
        {2'd2, 2'd1, 4'd3, 3'd3, 1'b0, 2'd0, 1'b1, 2'd2, 4'b0000}, // R6 cpu2 kept shared
        {2'd1, 2'd1, 4'd3, 3'd4, 1'b1, 2'd1, 1'b1, 2'd1, 4'b0100}, // R7 write miss, owner wb
        {2'd3, 2'd2, 4'd3, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}, // R8 nc write miss
        {2'd3, 2'd0, 4'd3, 3'd3, 1'b1, 2'd3, 1'b0, 2'd0, 4'b0010}, // R8 not allocated, owner kept
        {2'd3, 2'd2, 4'd3, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}, // R8 nc write on shared
        {2'd3, 2'd0, 4'd3, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}, // R8 still shared
        {2'd1, 2'd2, 4'd7, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}, // R8 nc write cold line
        {2'd1, 2'd0, 4'd7, 3'd3, 1'b1, 2'd1, 1'b0, 2'd0, 4'b0000}, // R8 still a miss
        {2'd0, 2'd0, 4'd9, 3'd3, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000}, // R4 other line
        {2'd0, 2'd3, 4'd9, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}  // R2 spare code reads
    };
    localparam string ROW_REQ [NV] = '{"R4", "R2", "R6", "R2", "R5", "R7", "R5", "R6",
                                       "R7", "R8", "R8", "R8", "R8", "R8", "R8", "R4", "R2"};

    task automatic run_req(input int cpu, input int op, input int addr,
                           output int lat, output int mb, output int cb,
                           output int wbm, output int aok);
        lat = 0; mb = 0; cb = 0; wbm = 0; aok = 1;
        @(negedge clk);
        req_valid[cpu] = 1'b1;
        req_op[2*cpu +: 2] = op[1:0];
        req_addr[4*cpu +: 4] = addr[3:0];
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            req_valid[cpu] = 1'b0;
            if (mbus_valid && mb == 0) begin
                mb = 4 + int'(mbus_src);
                if (int'(mbus_addr) != addr) aok = 0;
            end
            if (cbus_valid && cb == 0) begin
                cb = 4 + int'(cbus_src);
                if (int'(cbus_addr) != addr) aok = 0;
            end
            wbm = wbm | int'(wb);
            if (req_done[cpu]) begin
                lat = k;
                break;
            end
        end
    endtask

    int done_at [4];
    int mb_t [16];
    int cb_t [16];
    int wb_t [16];

    task automatic run_multi(input logic [3:0] mask, input logic [7:0] ops, input logic [15:0] addrs);
        for (int c = 0; c < 4; c++) done_at[c] = 0;
        for (int k = 0; k < 16; k++) begin mb_t[k] = 0; cb_t[k] = 0; wb_t[k] = 0; end
        @(negedge clk);
        req_valid = mask;
        req_op = ops;
        req_addr = addrs;
        for (int k = 1; k < 16; k++) begin
            @(negedge clk);
            req_valid = '0;
            mb_t[k] = mbus_valid ? 4 + int'(mbus_src) : 0;
            cb_t[k] = cbus_valid ? 4 + int'(cbus_src) : 0;
            wb_t[k] = int'(wb);
            for (int c = 0; c < 4; c++)
                if (req_done[c] && done_at[c] == 0) done_at[c] = k;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lat, mb, cb, wbm, aok;
        repeat (3) @(negedge clk);
        // R1: reset state while held and after release
        check_eq("R1", "ready in reset", int'(req_ready), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ready", int'(req_ready), 15);
        check_eq("R1", "done", int'(req_done), 0);
        check_eq("R1", "bus idle", int'(mbus_valid) + int'(cbus_valid), 0);
        check_eq("R1", "wb", int'(wb), 0);

        for (int r = 0; r < NV; r++) begin
            logic [20:0] v;
            v = VEC[r];
            run_req(int'(v[20:19]), int'(v[18:17]), int'(v[16:13]), lat, mb, cb, wbm, aok);
            check_eq(ROW_REQ[r], $sformatf("row %0d latency", r), lat, int'(v[12:10]));
            check_eq(ROW_REQ[r], $sformatf("row %0d mbus", r), mb, v[9] ? 4 + int'(v[8:7]) : 0);
            check_eq(ROW_REQ[r], $sformatf("row %0d cbus", r), cb, v[6] ? 4 + int'(v[5:4]) : 0);
            check_eq(ROW_REQ[r], $sformatf("row %0d wb", r), wbm, int'(v[3:0]));
            check_eq(ROW_REQ[r], $sformatf("row %0d bus addr", r), aok, 1);
        end

        // R9 R10: cpu1 and cpu2 both shared on line 5, both write at once
        run_req(1, 0, 5, lat, mb, cb, wbm, aok);
        run_req(2, 0, 5, lat, mb, cb, wbm, aok);
        check_eq("R2", "cpu2 read of line 5 shares", lat, 3);
        run_multi(4'b0110, 8'b00_01_01_00, {4'd0, 4'd5, 4'd5, 4'd0});
        check_eq("R9", "cbus first grant to cpu1", cb_t[2], 5);
        check_eq("R9", "cpu1 done", done_at[1], 3);
        check_eq("R10", "loser silent after invalidation", cb_t[3], 0);
        check_eq("R10", "loser refetch", mb_t[4], 6);
        check_eq("R5", "cpu1 writes back on refetch", wb_t[4], 2);
        check_eq("R10", "loser invalidates again", cb_t[5], 6);
        check_eq("R10", "cpu2 done", done_at[2], 6);

        // R9: simultaneous misses on line 11 from cpu0 and cpu3
        run_multi(4'b1001, 8'b00_00_00_00, {4'd11, 4'd0, 4'd0, 4'd11});
        check_eq("R9", "mbus first grant cpu0", mb_t[2], 4);
        check_eq("R9", "mbus second grant cpu3", mb_t[3], 7);
        check_eq("R9", "cpu0 done", done_at[0], 3);
        check_eq("R9", "cpu3 done", done_at[3], 4);

        // R11: cpu2 fetches line 4 while shared holder cpu1 upgrades it
        run_req(1, 0, 4, lat, mb, cb, wbm, aok);
        run_multi(4'b0110, 8'b00_00_01_00, {4'd0, 4'd4, 4'd4, 4'd0});
        check_eq("R11", "fetch goes first", mb_t[2], 6);
        check_eq("R11", "invalidate held back", cb_t[2], 0);
        check_eq("R11", "invalidate next cycle", cb_t[3], 5);
        check_eq("R11", "cpu2 done", done_at[2], 3);
        check_eq("R11", "cpu1 done", done_at[1], 4);
        run_req(2, 0, 4, lat, mb, cb, wbm, aok);
        check_eq("R6", "cpu2 copy invalidated", lat, 3);
        check_eq("R5", "cpu1 owner writes back", wbm, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule